// File: doc/BRIEF.md
# Converter Soft-Start Sequencer

This block sequences the power stage of a digitally controlled step-down converter. It advances on a periodic scheduler tick of nominally 100 µs. After reset it moves through initialise, reset and standby. From standby it runs a power-on delay, a ramp launch, a reference ramp and a power-good delay, and then settles in regulation. It drives the PWM output enable, the control-loop enable, a one-cycle pulse that clears the compensator history, and the voltage reference that the outer loop tracks.

When the output is already charged at ramp launch, the reference starts from the measured output voltage, so the supply does not first pull the rail down. Once in regulation, a new target is approached one bounded step per tick and never in a single jump. A fault, or the enable bit dropping, sends the sequencer to a suspend state within one clock. That state shuts off the stage, zeroes the reference and clears the controller history. It returns to reset once the condition has gone.

Top module: `buck_seq_top`

## Requirements
- R1: While and directly after synchronous reset the state code is 0 (initialise), `vref` is 0 and `pwm_en`, `loop_en`, `pgood` and `hist_clr` are all low.
- R2: Without abort, successive ticks move the state from initialise (0) to reset (1) to standby (2), with the PWM and the loop kept off.
- R3: Standby (2) goes to power-on delay (3) only on a tick with `go` high. With `go` low it stays in standby at every tick.
- R4: The power-on delay lasts exactly `POD_TICKS` ticks with the PWM and the loop off, and then the state becomes launch (4).
- R5: The tick in launch loads `vref` with the lesser of `vout_meas` and `vref_target` (0 when `vout_meas` is 0) and moves the state to ramp (5).
- R6: In ramp each tick moves `vref` toward `vref_target` by `STEP`, without overshooting the target. The tick that lands on the target moves the state to power-good delay (6). `pwm_en` and `loop_en` are high exactly in states 5, 6 and 7.
- R7: The power-good delay lasts exactly `PGD_TICKS` ticks, and then the state becomes online (7). `pgood` is high only in state 7.
- R8: In online, each tick moves `vref` toward the current `vref_target` by at most `STEP`, in either direction, and stops at the target.
- R9: A clock edge with `fault` high or `enable` low puts the block in suspend (8), with or without a tick and from any state. On that same edge `vref` becomes 0 and `pwm_en`, `loop_en` and `pgood` go low.
- R10: `hist_clr` is high for exactly the first clock cycle spent in suspend.
- R11: Suspend holds while `fault` is high or `enable` is low. Once both are clear, the next tick moves the state to reset (1).
- R12: Without a tick and without abort, neither the state code nor `vref` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle sequencer step strobe |
| enable | input | 1 | Converter enable; low forces suspend |
| go | input | 1 | Start permission, sampled in standby |
| fault | input | 1 | Any fault active; forces suspend |
| vout_meas | input | W | Measured output voltage code |
| vref_target | input | W | Nominal reference target code |
| pwm_en | output | 1 | PWM outputs enabled |
| loop_en | output | 1 | Control loop running |
| hist_clr | output | 1 | Clear compensator history (pulse) |
| vref | output | W | Present voltage reference |
| pgood | output | 1 | Power good (online only) |
| state_code | output | 4 | Sequencer state code |

## Verification
The start-up path is swept over several pre-bias levels: zero, small, mid-range, exactly at the target and above it. These runs separate a ramp that restarts from zero, one that resumes from the rail, one that launches straight into the power-good delay, and one that clamps to the target. In regulation, target moves down and then up near full scale show whether stepping is bounded, symmetric and free of overshoot or wrap-around. Abort is applied through `fault` during regulation and through `enable` during the ramp, and idle clocks with no tick are checked. These cases show whether suspend is taken at once and whether it waits for the condition to clear.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [3:0] {
        ST_INIT    = 4'd0,
        ST_RESET   = 4'd1,
        ST_STANDBY = 4'd2,
        ST_POD     = 4'd3,
        ST_LAUNCH  = 4'd4,
        ST_RAMP    = 4'd5,
        ST_PGD     = 4'd6,
        ST_ONLINE  = 4'd7,
        ST_SUSPEND = 4'd8
    } seq_state_e;

    typedef enum logic [1:0] {
        REF_HOLD = 2'd0,
        REF_ZERO = 2'd1,
        REF_LOAD = 2'd2,
        REF_STEP = 2'd3
    } ref_op_e;

    typedef struct packed {
        logic pwm_en;
        logic loop_en;
        logic pgood;
    } stage_drive_t;

    function automatic stage_drive_t drive_of(seq_state_e s);
        stage_drive_t d;
        d.pwm_en  = (s == ST_RAMP) || (s == ST_PGD) || (s == ST_ONLINE);
        d.loop_en = d.pwm_en;
        d.pgood   = (s == ST_ONLINE);
        return d;
    endfunction

endpackage

// File: rtl/seq_tick_timer.sv
module seq_tick_timer #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic adv,
    output logic done
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt;

    assign done = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !arm)
            cnt <= '0;
        else if (adv && !done)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/seq_ref_gen.sv
module seq_ref_gen
    import seq_pkg::*;
#(
    parameter int W    = 10,
    parameter int STEP = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  ref_op_e      op,
    input  logic [W-1:0] vout_meas,
    input  logic [W-1:0] target,
    output logic [W-1:0] vref,
    output logic         step_lands
);
    localparam logic [W:0]   STEP_X = (W+1)'(STEP);
    localparam logic [W-1:0] STEP_N = W'(STEP);

    function automatic logic [W-1:0] step_toward(logic [W-1:0] cur, logic [W-1:0] tgt);
        logic [W:0] up;
        logic [W:0] lim;
        up  = {1'b0, cur} + STEP_X;
        lim = {1'b0, tgt} + STEP_X;
        if (cur < tgt)
            return (up >= {1'b0, tgt}) ? tgt : up[W-1:0];
        else if (cur > tgt)
            return ({1'b0, cur} <= lim) ? tgt : (cur - STEP_N);
        else
            return cur;
    endfunction

    logic [W-1:0] stepped;
    logic [W-1:0] launch_val;

    assign stepped    = step_toward(vref, target);
    assign step_lands = (stepped == target);
    assign launch_val = (vout_meas == '0)    ? '0     :
                        (vout_meas > target) ? target : vout_meas;

    always_ff @(posedge clk) begin
        if (rst) begin
            vref <= '0;
        end else begin
            unique case (op)
                REF_ZERO: vref <= '0;
                REF_LOAD: vref <= launch_val;
                REF_STEP: vref <= stepped;
                default:  vref <= vref;
            endcase
        end
    end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       abort,
    input  logic       go,
    input  logic       pod_done,
    input  logic       pgd_done,
    input  logic       step_lands,
    output seq_state_e state,
    output ref_op_e    op,
    output logic       hist_clr
);
    seq_state_e nxt;

    always_comb begin
        nxt = state;
        op  = REF_HOLD;
        if (abort) begin
            nxt = ST_SUSPEND;
            op  = REF_ZERO;
        end else begin
            unique case (state)
                ST_INIT:    if (tick) nxt = ST_RESET;
                ST_RESET: begin
                    op = REF_ZERO;
                    if (tick) nxt = ST_STANDBY;
                end
                ST_STANDBY: if (tick && go) nxt = ST_POD;
                ST_POD:     if (tick && pod_done) nxt = ST_LAUNCH;
                ST_LAUNCH: begin
                    if (tick) begin
                        op  = REF_LOAD;
                        nxt = ST_RAMP;
                    end
                end
                ST_RAMP: begin
                    if (tick) begin
                        op = REF_STEP;
                        if (step_lands) nxt = ST_PGD;
                    end
                end
                ST_PGD:     if (tick && pgd_done) nxt = ST_ONLINE;
                ST_ONLINE:  if (tick) op = REF_STEP;
                ST_SUSPEND: begin
                    op = REF_ZERO;
                    if (tick) nxt = ST_RESET;
                end
                default:    nxt = ST_INIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_INIT;
            hist_clr <= 1'b0;
        end else begin
            state    <= nxt;
            hist_clr <= (nxt == ST_SUSPEND) && (state != ST_SUSPEND);
        end
    end
endmodule

// File: rtl/buck_seq_top.sv
module buck_seq_top
    import seq_pkg::*;
#(
    parameter int W         = 10,
    parameter int STEP      = 16,
    parameter int POD_TICKS = 3,
    parameter int PGD_TICKS = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         enable,
    input  logic         go,
    input  logic         fault,
    input  logic [W-1:0] vout_meas,
    input  logic [W-1:0] vref_target,
    output logic         pwm_en,
    output logic         loop_en,
    output logic         hist_clr,
    output logic [W-1:0] vref,
    output logic         pgood,
    output logic [3:0]   state_code
);
    seq_state_e   state;
    ref_op_e      op;
    stage_drive_t drv;
    logic         abort;
    logic         pod_done;
    logic         pgd_done;
    logic         step_lands;

    assign abort = fault || !enable;

    seq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .abort      (abort),
        .go         (go),
        .pod_done   (pod_done),
        .pgd_done   (pgd_done),
        .step_lands (step_lands),
        .state      (state),
        .op         (op),
        .hist_clr   (hist_clr)
    );

    seq_tick_timer #(.LEN(POD_TICKS)) u_pod (
        .clk  (clk),
        .rst  (rst),
        .arm  (state == ST_POD),
        .adv  (tick),
        .done (pod_done)
    );

    seq_tick_timer #(.LEN(PGD_TICKS)) u_pgd (
        .clk  (clk),
        .rst  (rst),
        .arm  (state == ST_PGD),
        .adv  (tick),
        .done (pgd_done)
    );

    seq_ref_gen #(.W(W), .STEP(STEP)) u_ref (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .vout_meas  (vout_meas),
        .target     (vref_target),
        .vref       (vref),
        .step_lands (step_lands)
    );

    assign drv        = drive_of(state);
    assign pwm_en     = drv.pwm_en;
    assign loop_en    = drv.loop_en;
    assign pgood      = drv.pgood;
    assign state_code = state;
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
    parameter int W    = 10,
    parameter int STEP = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         tick,
    input logic         enable,
    input logic         fault,
    input logic         pwm_en,
    input logic         loop_en,
    input logic         hist_clr,
    input logic [W-1:0] vref,
    input logic         pgood,
    input logic [3:0]   state_code
);
    a_r9_abort_suspend: assert property (@(posedge clk) disable iff (rst)
        (fault || !enable) |=> (state_code == 4'd8 && vref == '0 && !pwm_en && !loop_en));

    a_r10_hist_single: assert property (@(posedge clk) disable iff (rst)
        hist_clr |=> !hist_clr);

    a_r10_hist_in_suspend: assert property (@(posedge clk) disable iff (rst)
        hist_clr |-> (state_code == 4'd8));

    a_r7_pgood_online: assert property (@(posedge clk) disable iff (rst)
        pgood |-> (state_code == 4'd7 && pwm_en && loop_en));

    a_r11_suspend_holds: assert property (@(posedge clk) disable iff (rst)
        (state_code == 4'd8 && (fault || !enable)) |=> (state_code == 4'd8));

    a_r12_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !fault && enable) |=> ($stable(state_code) && $stable(vref)));

    a_r8_online_bounded: assert property (@(posedge clk) disable iff (rst)
        (state_code == 4'd7 && !fault && enable) |=>
        ((vref >= $past(vref)) ? ((vref - $past(vref)) <= W'(STEP))
                               : (($past(vref) - vref) <= W'(STEP))));
endmodule

bind buck_seq_top seq_checker #(.W(W), .STEP(STEP)) u_seq_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .enable     (enable),
    .fault      (fault),
    .pwm_en     (pwm_en),
    .loop_en    (loop_en),
    .hist_clr   (hist_clr),
    .vref       (vref),
    .pgood      (pgood),
    .state_code (state_code)
);

// File: tb/tb_buck_seq_top.sv
module tb_buck_seq_top;
    localparam int W    = 10;
    localparam int STEP = 16;
    localparam int PODN = 3;
    localparam int PGDN = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick = 1'b0;
    logic         enable = 1'b0;
    logic         go = 1'b0;
    logic         fault = 1'b0;
    logic [W-1:0] vout_meas = '0;
    logic [W-1:0] vref_target = '0;
    logic         pwm_en, loop_en, hist_clr, pgood;
    logic [W-1:0] vref;
    logic [3:0]   state_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    buck_seq_top #(.W(W), .STEP(STEP), .POD_TICKS(PODN), .PGD_TICKS(PGDN)) dut (
        .clk(clk), .rst(rst), .tick(tick), .enable(enable), .go(go), .fault(fault),
        .vout_meas(vout_meas), .vref_target(vref_target), .pwm_en(pwm_en),
        .loop_en(loop_en), .hist_clr(hist_clr), .vref(vref), .pgood(pgood),
        .state_code(state_code)
    );

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // State plus the drive outputs implied by it (pwm/loop in 5..7, pgood in 7)
    task automatic chk_state(string req, int exp);
        chk({req, " state"}, int'(state_code), exp);
        chk({req, " pwm_en"}, int'(pwm_en), (exp >= 5 && exp <= 7) ? 1 : 0);
        chk({req, " loop_en"}, int'(loop_en), (exp >= 5 && exp <= 7) ? 1 : 0);
        chk({req, " pgood"}, int'(pgood), (exp == 7) ? 1 : 0);
    endtask

    task automatic do_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int model_step(int cur, int tgt);
        if (cur < tgt) return (cur + STEP >= tgt) ? tgt : cur + STEP;
        if (cur > tgt) return (cur - STEP <= tgt) ? tgt : cur - STEP;
        return cur;
    endfunction

    task automatic bring_up(int pb, int tgt);
        int exp;
        int nxt;
        @(negedge clk);
        rst = 1'b1; go = 1'b0; fault = 1'b0; enable = 1'b1;
        vout_meas = W'(pb); vref_target = W'(tgt);
        idle(2);
        rst = 1'b0;
        idle(1);
        chk_state("R1 after reset", 0);
        chk("R1 vref", int'(vref), 0);
        chk("R1 hist_clr", int'(hist_clr), 0);
        do_tick(); chk_state("R2 init->reset", 1);
        do_tick(); chk_state("R2 reset->standby", 2);
        do_tick(); chk_state("R3 go low holds", 2);
        go = 1'b1;
        do_tick(); chk_state("R3 go high leaves", 3);
        for (int i = 1; i < PODN; i++) begin
            do_tick(); chk_state("R4 delay in progress", 3);
        end
        do_tick(); chk_state("R4 delay expired", 4);
        exp = (pb > tgt) ? tgt : pb;
        do_tick();
        chk_state("R5 launch->ramp", 5);
        chk("R5 preload", int'(vref), exp);
        for (int g = 0; g < 200; g++) begin
            nxt = model_step(exp, tgt);
            do_tick();
            chk("R6 ramp vref", int'(vref), nxt);
            exp = nxt;
            if (nxt == tgt) begin
                chk_state("R6 ramp done", 6);
                break;
            end
            chk_state("R6 ramping", 5);
        end
        for (int i = 1; i < PGDN; i++) begin
            do_tick(); chk_state("R7 pg delay", 6);
        end
        do_tick(); chk_state("R7 online", 7);
        chk("R7 vref held", int'(vref), tgt);
    endtask

    task automatic track(int tgt);
        int exp;
        exp = int'(vref);
        vref_target = W'(tgt);
        for (int g = 0; g < 200 && exp != tgt; g++) begin
            exp = model_step(exp, tgt);
            do_tick();
            chk("R8 online vref", int'(vref), exp);
            chk_state("R8 stays online", 7);
        end
    endtask

    initial begin
        int pbs[5] = '{0, 5, 150, 400, 600};
        foreach (pbs[k]) bring_up(pbs[k], 400);

        // R8: down, up to near full scale, then back
        track(350);
        track(1020);
        track(1023);
        track(990);

        // R12: no tick, no state/vref change
        vref_target = W'(500);
        idle(5);
        chk_state("R12 no tick", 7);
        chk("R12 vref stable", int'(vref), 990);
        vref_target = W'(990);

        // R9 / R10 / R11 via fault without tick
        fault = 1'b1;
        idle(1);
        chk_state("R9 fault suspend", 8);
        chk("R9 vref zero", int'(vref), 0);
        chk("R10 hist pulse", int'(hist_clr), 1);
        idle(1);
        chk("R10 hist single", int'(hist_clr), 0);
        do_tick();
        chk_state("R11 held while fault", 8);
        fault = 1'b0;
        idle(3);
        chk_state("R11 waits for tick", 8);
        do_tick();
        chk_state("R11 suspend->reset", 1);

        // R9 via enable drop during ramp
        do_tick(); chk_state("R2 reset->standby again", 2);
        vout_meas = '0; vref_target = W'(400);
        do_tick(); chk_state("R3 restart", 3);
        for (int i = 0; i < PODN; i++) do_tick();
        do_tick();
        do_tick();
        chk_state("R6 ramping again", 5);
        chk("R6 first step", int'(vref), STEP);
        enable = 1'b0;
        idle(1);
        chk_state("R9 enable drop suspend", 8);
        chk("R9 vref zero enable", int'(vref), 0);
        chk("R10 hist pulse enable", int'(hist_clr), 1);
        enable = 1'b1;
        do_tick();
        chk_state("R11 recovers", 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule